// File: doc/BRIEF.md
# Timer Capture/Compare Status Flags

This block is one timer channel with a free-running 16-bit up counter and two general registers, C and D. Each general register works either as an output-compare register or as an input-capture register, chosen by its own mode pin. Every general register owns a status flag. The flag goes high when the counter equals the register in compare mode. In capture mode the flag goes high when a capture strobe latches the counter into the register.

Software reads and writes the counter, both general registers, a status register and an interrupt-enable register through a plain register port. That port accepts an access on every cycle and never stalls, so there is no back-pressure to handle. A flag is cleared in one of two ways. Software can read the flag as 1 and then write 0 to it. A transfer acknowledge can also clear it, provided that acknowledge's disable pin is low. Each flag drives a level interrupt request, gated by its enable bit. A build parameter removes registers C and D. With them removed, their bits read 0 and ignore writes.

Top module: `cc_status_timer`

## Requirements
- R1: After reset the counter, both general registers, both flags, both interrupt enables and both interrupt outputs are 0.
- R2: The counter adds 1 every clock, wraps from FFFFh to 0000h, and takes the written value when address 0 is written.
- R3: With its mode pin at 0 (compare), a register's flag is 1 from the clock after the cycle in which the counter equals that register.
- R4: With its mode pin at 1 (capture), a strobe loads the register with the counter value of the same cycle and sets the flag. In that mode the compare has no effect, and in compare mode the strobe has no effect.
- R5: The status register (address 3) carries flag C at bit 2 and flag D at bit 3. Writing 1 to either bit never sets it and never clears it.
- R6: Writing 0 to a flag bit clears the flag only if a status read returned that flag as 1 since the last status write. A 0 write without such a read leaves the flag set.
- R7: Any status write consumes the read-as-1 permission, whatever value it writes.
- R8: A transfer acknowledge clears its flag when the matching disable pin is 0, and has no effect when that pin is 1.
- R9: A set event and a clear event in the same cycle leave the flag at 1.
- R10: Address 4 holds the interrupt enables: bit 2 for C and bit 3 for D. Each interrupt output equals its flag AND its enable.
- R11: With HAS_CD = 0, the general registers, the status bits and the enable bits read 0, writes to them have no effect, and both interrupt outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | 0 counter, 1 reg C, 2 reg D, 3 status, 4 enables |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational, 0 when not reading) |
| cap_mode | input | 2 | Per register mode, bit 0 = C, bit 1 = D; 1 = capture |
| cap_stb | input | 2 | Capture strobes, bit 0 = C, bit 1 = D |
| xfer_ack | input | 2 | Transfer acknowledge per flag |
| xfer_dis | input | 2 | Disable automatic clear for the matching acknowledge |
| irq | output | 2 | Interrupt request per flag, bit 0 = C, bit 1 = D |

## Verification
Compare matches are triggered by loading the counter just below each register value, so the two flags rise on different, known cycles. Capture strobes land on single cycles, which separates a load of the same-cycle counter value from a load that is off by one. The clear handshake is tried four ways: write without a read, read then write 0, read then a write of 1s followed by a write of 0, and collisions of set and clear in one cycle. Together these separate the armed permission from a plain zero-write clear and from clear-over-set priority. Transfer acknowledges are driven with the disable pin high and then low. A second instance built without registers C and D receives the same stimulus throughout and is expected to stay silent.

// File: rtl/cst_pkg.sv
`timescale 1ns/1ps
package cst_pkg;
  localparam int ADDR_W   = 3;
  localparam int NSLOT    = 2;   // index 0 = register C, 1 = register D
  localparam int FLAG_LSB = 2;   // C flag at bit 2, D flag at bit 3
  typedef enum logic [ADDR_W-1:0] {
    RA_CNT  = 3'd0,
    RA_GRC  = 3'd1,
    RA_GRD  = 3'd2,
    RA_STAT = 3'd3,
    RA_IEN  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/cst_counter.sv
`timescale 1ns/1ps
module cst_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt <= '0;
    else if (ld) cnt <= ld_val;
    else         cnt <= cnt + W'(1);
  end

  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> cnt == $past(cnt) + W'(1));
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && cnt == {W{1'b1}}) |=> cnt == '0);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt == $past(ld_val));
endmodule

// File: rtl/cst_slot.sv
`timescale 1ns/1ps
module cst_slot #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt,
  input  logic         cap_mode,
  input  logic         cap_stb,
  input  logic         gr_wr,
  input  logic [W-1:0] gr_wval,
  input  logic         stat_rd,
  input  logic         stat_wr,
  input  logic         stat_wbit,
  input  logic         xfer_ack,
  input  logic         xfer_dis,
  output logic [W-1:0] gr,
  output logic         flag
);
  logic cmp_hit, cap_hit, set_evt;
  logic sw_clr, hw_clr, armed;

  assign cmp_hit = !cap_mode && (cnt == gr);
  assign cap_hit = cap_mode && cap_stb;
  assign set_evt = cmp_hit || cap_hit;
  assign sw_clr  = stat_wr && !stat_wbit && armed;
  assign hw_clr  = xfer_ack && !xfer_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gr <= '0;
    else if (cap_hit) gr <= cnt;
    else if (gr_wr)   gr <= gr_wval;
  end

  // read-as-1 permission: any status write uses it up
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (stat_wr) armed <= 1'b0;
    else if (stat_rd && flag) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (set_evt)           flag <= 1'b1;
    else if (sw_clr || hw_clr)  flag <= 1'b0;
  end

  a_r4_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    cap_hit |=> gr == $past(cnt));
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  a_r5_only_events_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(set_evt));
  a_r6_clear_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(sw_clr || hw_clr));
  a_r7_write_consumes: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> !armed);
endmodule

// File: rtl/cc_status_timer.sv
`timescale 1ns/1ps
module cc_status_timer
  import cst_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit HAS_CD = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic [NSLOT-1:0] cap_mode,
  input  logic [NSLOT-1:0] cap_stb,
  input  logic [NSLOT-1:0] xfer_ack,
  input  logic [NSLOT-1:0] xfer_dis,
  output logic [NSLOT-1:0] irq
);
  localparam int NS = NSLOT;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] gr [NS];
  logic [NS-1:0]    flag;
  logic [NS-1:0]    ien;
  logic             acc_rd, acc_wr;
  logic             rd_stat, wr_stat, wr_cnt, wr_ien;
  logic [NS-1:0]    wr_gr;

  assign acc_rd   = bus_sel && !bus_wr;
  assign acc_wr   = bus_sel && bus_wr;
  assign rd_stat  = acc_rd && (bus_addr == RA_STAT);
  assign wr_stat  = acc_wr && (bus_addr == RA_STAT);
  assign wr_cnt   = acc_wr && (bus_addr == RA_CNT);
  assign wr_ien   = acc_wr && (bus_addr == RA_IEN);
  assign wr_gr[0] = acc_wr && (bus_addr == RA_GRC);
  assign wr_gr[1] = acc_wr && (bus_addr == RA_GRD);

  cst_counter #(.W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ld     (wr_cnt),
    .ld_val (bus_wdata),
    .cnt    (cnt)
  );

  generate
    if (HAS_CD) begin : g_cd
      for (genvar i = 0; i < NS; i++) begin : g_slot
        cst_slot #(.W(CNT_W)) u_slot (
          .clk       (clk),
          .rst_n     (rst_n),
          .cnt       (cnt),
          .cap_mode  (cap_mode[i]),
          .cap_stb   (cap_stb[i]),
          .gr_wr     (wr_gr[i]),
          .gr_wval   (bus_wdata),
          .stat_rd   (rd_stat),
          .stat_wr   (wr_stat),
          .stat_wbit (bus_wdata[FLAG_LSB+i]),
          .xfer_ack  (xfer_ack[i]),
          .xfer_dis  (xfer_dis[i]),
          .gr        (gr[i]),
          .flag      (flag[i])
        );
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien <= '0;
        else if (wr_ien) ien <= bus_wdata[FLAG_LSB +: NS];
      end
    end else begin : g_nocd
      for (genvar i = 0; i < NS; i++) begin : g_zero
        assign gr[i] = '0;
      end
      assign flag = '0;
      assign ien  = '0;
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (acc_rd) begin
      case (bus_addr)
        RA_CNT:  bus_rdata = cnt;
        RA_GRC:  bus_rdata = gr[0];
        RA_GRD:  bus_rdata = gr[1];
        RA_STAT: bus_rdata[FLAG_LSB +: NS] = flag;
        RA_IEN:  bus_rdata[FLAG_LSB +: NS] = ien;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = flag & ien;

  a_r10_irq_off_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ien && bus_wdata[FLAG_LSB +: NS] == '0) |=> irq == '0);
endmodule

// File: tb/tb_cc_status_timer.sv
`timescale 1ns/1ps
module tb_cc_status_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic [1:0]  cap_mode, cap_stb, xfer_ack, xfer_dis;
  logic [15:0] rdata_a, rdata_b;
  logic [1:0]  irq_a, irq_b;

  always #2 clk = ~clk;

  cc_status_timer #(.CNT_W(16), .HAS_CD(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
    .cap_mode(cap_mode), .cap_stb(cap_stb), .xfer_ack(xfer_ack),
    .xfer_dis(xfer_dis), .irq(irq_a));

  cc_status_timer #(.CNT_W(16), .HAS_CD(1'b0)) dut_nocd (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
    .cap_mode(cap_mode), .cap_stb(cap_stb), .xfer_ack(xfer_ack),
    .xfer_dis(xfer_dis), .irq(irq_b));

  int compared = 0, mismatched = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural reference
  int m_cnt, m_gr[2], m_fl[2], m_arm[2], m_ien[2];
  int n_cnt, n_gr[2], n_fl[2], n_arm[2];
  bit rd_st, wr_st, set_e, clr_e;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      for (int i = 0; i < 2; i++) begin
        m_gr[i] = 0; m_fl[i] = 0; m_arm[i] = 0; m_ien[i] = 0;
      end
    end else begin
      rd_st = bus_sel && !bus_wr && bus_addr == 3;
      wr_st = bus_sel && bus_wr && bus_addr == 3;
      n_cnt = (bus_sel && bus_wr && bus_addr == 0) ? int'(bus_wdata) : (m_cnt + 1) % 65536;
      for (int i = 0; i < 2; i++) begin
        set_e = cap_mode[i] ? cap_stb[i] : (m_cnt == m_gr[i]);
        clr_e = (wr_st && !bus_wdata[2+i] && m_arm[i] != 0) || (xfer_ack[i] && !xfer_dis[i]);
        n_fl[i]  = set_e ? 1 : (clr_e ? 0 : m_fl[i]);
        n_arm[i] = wr_st ? 0 : ((rd_st && m_fl[i] != 0) ? 1 : m_arm[i]);
        if (cap_mode[i] && cap_stb[i]) n_gr[i] = m_cnt;
        else if (bus_sel && bus_wr && bus_addr == 3'(1 + i)) n_gr[i] = int'(bus_wdata);
        else n_gr[i] = m_gr[i];
      end
      if (bus_sel && bus_wr && bus_addr == 4) begin
        m_ien[0] = bus_wdata[2]; m_ien[1] = bus_wdata[3];
      end
      m_cnt = n_cnt;
      for (int i = 0; i < 2; i++) begin
        m_gr[i] = n_gr[i]; m_fl[i] = n_fl[i]; m_arm[i] = n_arm[i];
      end
    end
  end

  function automatic logic [15:0] exp_rd(bit cd);
    logic [15:0] v = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        3'd0: v = 16'(m_cnt);
        3'd1: v = cd ? 16'(m_gr[0]) : '0;
        3'd2: v = cd ? 16'(m_gr[1]) : '0;
        3'd3: if (cd) begin v[2] = m_fl[0][0]; v[3] = m_fl[1][0]; end
        3'd4: if (cd) begin v[2] = m_ien[0][0]; v[3] = m_ien[1][0]; end
        default: v = '0;
      endcase
    end
    return v;
  endfunction

  task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual %h expected %h at %0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      chk(cur_req, "rdata", rdata_a, exp_rd(1'b1));
      chk(cur_req, "irq", {14'd0, irq_a},
          {14'd0, 1'(m_fl[1] & m_ien[1]), 1'(m_fl[0] & m_ien[0])});
      chk("R11", "nocd rdata", rdata_b, exp_rd(1'b0));
      chk("R11", "nocd irq", {14'd0, irq_b}, 16'd0);
    end
  end

  task automatic drive(input bit sel, input bit wr, input logic [2:0] a, input logic [15:0] d,
                       input logic [1:0] stb, input logic [1:0] ack, input logic [1:0] dis);
    @(negedge clk);
    bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
    cap_stb = stb; xfer_ack = ack; xfer_dis = dis;
  endtask
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1, 0, 3'd0, 16'd0, 2'b00, 2'b00, 2'b00);
  endtask
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    drive(1, 1, a, d, 2'b00, 2'b00, 2'b00);
  endtask
  task automatic rd(input logic [2:0] a);
    drive(1, 0, a, 16'd0, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      compared++; mismatched++;
      $display("FAIL watchdog run did not finish actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    cap_mode = 2'b11; cap_stb = 0; xfer_ack = 0; xfer_dis = 0;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(3'd3); rd(3'd4); rd(3'd1); rd(3'd2); idle(2);
    cur_req = "R10"; wr(3'd4, 16'h000C); rd(3'd4);
    cur_req = "R2"; wr(3'd0, 16'hFFFC); idle(7);
    cur_req = "R3";
    wr(3'd1, 16'h0050); wr(3'd2, 16'h0053); wr(3'd0, 16'h004C);
    @(negedge clk); cap_mode = 2'b00; bus_sel = 1; bus_wr = 0; bus_addr = 0;
    idle(10);
    cur_req = "R5"; wr(3'd3, 16'hFFFF); idle(2);
    cur_req = "R6"; wr(3'd3, 16'h0000); idle(2); rd(3'd3); wr(3'd3, 16'h0000); idle(2);
    cur_req = "R4";
    @(negedge clk); cap_mode = 2'b11;
    wr(3'd0, 16'h1200); idle(3);
    drive(1, 0, 3'd0, 16'd0, 2'b01, 2'b00, 2'b00); idle(2); rd(3'd1);
    drive(1, 0, 3'd0, 16'd0, 2'b10, 2'b00, 2'b00); idle(1); rd(3'd2); idle(2);
    cur_req = "R7"; rd(3'd3); wr(3'd3, 16'h000C); wr(3'd3, 16'h0000); idle(2);
    cur_req = "R8";
    drive(1, 0, 3'd0, 16'd0, 2'b00, 2'b11, 2'b11); idle(1);
    drive(1, 0, 3'd0, 16'd0, 2'b00, 2'b01, 2'b00); idle(1);
    drive(1, 0, 3'd0, 16'd0, 2'b00, 2'b10, 2'b00); idle(2);
    cur_req = "R9";
    drive(1, 0, 3'd0, 16'd0, 2'b11, 2'b00, 2'b00); idle(1); rd(3'd3);
    drive(1, 1, 3'd3, 16'h0000, 2'b01, 2'b00, 2'b00); idle(1); rd(3'd3);
    drive(1, 0, 3'd0, 16'd0, 2'b01, 2'b01, 2'b00); idle(2); rd(3'd3);
    cur_req = "R10"; wr(3'd4, 16'h0004); idle(2); wr(3'd4, 16'h0008); idle(1); wr(3'd4, 16'h0000); idle(2);
    cur_req = "R11"; wr(3'd1, 16'h1234); rd(3'd1); wr(3'd4, 16'h000C); rd(3'd4); rd(3'd3); idle(2);
    done = 1;
    summary();
    $finish;
  end
endmodule